// File: doc/BRIEF.md
# Serial-Addressed Trim Code Bank

This block is the digital front end of a twelve-channel trim converter. A host writes it over a three-wire serial link made of an active-low select, a serial clock and a data line. Each complete frame carries a 4-bit channel number and an 8-bit code. When the frame closes, the code is stored in that channel's holding register. All twelve codes are driven out in parallel to the analog stage, which is outside this block.

The serial pins may be asynchronous to the system clock. They pass through a synchronizer and edge detectors before any decision is made. The serial link has no back-pressure: a frame cannot be refused or stalled. A frame either lands in one register or is dropped whole. The host paces the serial clock slowly enough for the synchronizer, with at least three system clocks in each serial clock phase.

Reset loads every channel with the midscale code. A power-down input is mirrored on a status output. It never disturbs the stored codes, so the analog stage resumes from the same settings when power-down is released.

Top module: `trim_bank_top`

## Requirements
- R1: While `rst_n` is low, every channel code reads 0x80 and `pd_status` reads 0.
- R2: A frame is the run of serial bits sampled on rising `ser_clk` edges while `ser_cs_n` is low, most significant bit first. In a 12-bit frame, the first 4 bits are the channel number (0 to 11) and the last 8 bits are the code. The code appears on `codes[8*ch +: 8]`.
- R3: A frame of any length other than 12 bits, including 11 and 13 bits, changes no channel code.
- R4: A write changes only the addressed channel. All other channels keep their codes.
- R5: A 12-bit frame whose channel number is 12, 13, 14 or 15 changes no channel code.
- R6: Activity on `ser_clk` and `ser_din` while `ser_cs_n` is high changes no channel code.
- R7: `pd_status` equals the value `pd_req` held one system clock earlier. Raising or lowering `pd_req` leaves every code unchanged, and frames are still written normally while `pd_req` is high.
- R8: After the rising edge of `ser_cs_n` that closes a valid frame, the new code is visible after the fourth rising edge of `clk`, and not after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads midscale into every channel |
| ser_cs_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| pd_req | input | 1 | Power-down request for the analog stage |
| pd_status | output | 1 | Registered copy of the power-down request |
| codes | output | 96 | Twelve 8-bit channel codes, channel n in bits 8n+7:8n |

## Verification
The serial pins reach the frame logic two system clocks after a change, through the synchronizer and edge detector. The write strobe is registered one clock later, and the channel register is loaded one clock after that. A closing select edge therefore shows on `codes` after four clock edges, while `pd_status` lags `pd_req` by one. The bench drives every input on the falling clock edge and samples on the falling edge. It probes the latency exactly with a sample after the third rising edge, where the old code is expected, and one after the fourth, where the new code is expected. All other code comparisons are made ten clocks after a frame closes, once the frame has fully settled.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int CH_COUNT  = 12;
  localparam int CH_ADDR_W = 4;
  localparam int CODE_BITS = 8;
  localparam int SYNC_LEN  = 2;
  localparam logic [CODE_BITS-1:0] CODE_MID = 8'h80;
endpackage

// File: rtl/trim_sync_edge.sv
module trim_sync_edge #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL[g]}};
      else        chain <= {chain[STAGES-1:0], d_async[g]};
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/trim_frame_rx.sv
module trim_frame_rx #(
  parameter int ADDR_W = 4,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CODE_W-1:0] wr_code
);
  localparam int WORD_W = ADDR_W + CODE_W;
  localparam int LIM    = WORD_W + 1;
  localparam int CNT_W  = $clog2(LIM + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(LIM);

  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (!cs_lvl && sck_rise) begin
      sr <= {sr[WORD_W-2:0], din};
      if (cnt != CNT_LIM) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_code <= '0;
    end else begin
      wr_en   <= cs_rise && (cnt == CNT_FULL);
      wr_addr <= sr[WORD_W-1 -: ADDR_W];
      wr_code <= sr[CODE_W-1:0];
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LIM); // R3
  AST_WR_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cnt == CNT_FULL); // R3
  AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> $stable(sr)); // R6
endmodule

// File: rtl/trim_latch_bank.sv
module trim_latch_bank #(
  parameter int N_CH = 12,
  parameter int ADDR_W = 4,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] MID = 8'h80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_code,
  output logic [N_CH*CODE_W-1:0]   codes_flat
);
  localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(N_CH - 1);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    logic              hit;
    logic [CODE_W-1:0] code_q;
    assign hit = wr_en && (wr_addr == MY_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_q <= MID;
      else if (hit) code_q <= wr_code;
    end
    assign codes_flat[g*CODE_W +: CODE_W] = code_q;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr <= LAST_CH) |=>
      codes_flat[$past(wr_addr)*CODE_W +: CODE_W] == $past(wr_code)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(codes_flat)); // R4
  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > LAST_CH) |=> $stable(codes_flat)); // R5
endmodule

// File: rtl/trim_bank_top.sv
module trim_bank_top
  import trim_pkg::*;
#(
  parameter int N_CH   = CH_COUNT,
  parameter int ADDR_W = CH_ADDR_W,
  parameter int CODE_W = CODE_BITS,
  parameter int SYNC_STAGES = SYNC_LEN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_cs_n,
  input  logic                   ser_clk,
  input  logic                   ser_din,
  input  logic                   pd_req,
  output logic                   pd_status,
  output logic [N_CH*CODE_W-1:0] codes
);
  localparam int IDX_CS  = 2;
  localparam int IDX_SCK = 1;
  localparam int IDX_DIN = 0;

  logic [2:0] s_lvl, s_rise, s_fall;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CODE_W-1:0] wr_code;

  trim_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({ser_cs_n, ser_clk, ser_din}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  trim_frame_rx #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(s_lvl[IDX_CS]), .cs_rise(s_rise[IDX_CS]), .cs_fall(s_fall[IDX_CS]),
    .sck_rise(s_rise[IDX_SCK]), .din(s_lvl[IDX_DIN]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code)
  );

  trim_latch_bank #(.N_CH(N_CH), .ADDR_W(ADDR_W), .CODE_W(CODE_W), .MID(CODE_MID)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .codes_flat(codes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_status <= 1'b0;
    else        pd_status <= pd_req;
  end

  AST_PD_TRACK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> pd_status); // R7
  AST_PD_TRACK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_req |=> !pd_status); // R7
  AST_PD_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req != pd_status && !wr_en) |=> $stable(codes)); // R7
endmodule

// File: tb/tb_trim_bank_top.sv
module tb_trim_bank_top;
  localparam int NCH = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0, ser_cs_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, pd_req = 1'b0;
  logic pd_status;
  logic [NCH*8-1:0] codes;
  logic [7:0] exp_q [NCH];
  int checks = 0, failures = 0;
  bit done = 0;

  trim_bank_top dut (.clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .pd_req(pd_req), .pd_status(pd_status), .codes(codes));

  always #5 clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string req);
    int bad = -1;
    checks++;
    for (int ch = 0; ch < NCH; ch++)
      if (bad < 0 && codes[ch*8 +: 8] !== exp_q[ch]) bad = ch;
    if (bad >= 0) begin
      failures++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, bad, codes[bad*8 +: 8], exp_q[bad]);
    end
  endtask

  task automatic check_bit(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic frame_body(int nbits, logic [15:0] word);
    ser_cs_n = 1'b0;
    tick(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_din = word[i];
      tick(4);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
    end
    tick(4);
  endtask

  task automatic model(int nbits, logic [15:0] word);
    if (nbits == 12 && word[11:8] < 4'(NCH)) exp_q[word[11:8]] = word[7:0];
  endtask

  task automatic send(int nbits, logic [15:0] word);
    frame_body(nbits, word);
    ser_cs_n = 1'b1;
    model(nbits, word);
    tick(10);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int ch = 0; ch < NCH; ch++) exp_q[ch] = 8'h80;
    tick(3);
    check_all("R1");
    check_bit("R1 pd_status", pd_status, 1'b0);
    rst_n = 1'b1;
    tick(2);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_0a17);
    tick(1);
    do_reset();
    check_all("R1 after release");

    send(12, {4'd0, 8'h12});
    send(12, {4'd11, 8'hFE});
    check_all("R2 R4 edge channels");
    send(12, {4'd5, 8'h00});
    send(12, {4'd6, 8'hFF});
    check_all("R2 R4 extreme codes");

    send(12, {4'd12, 8'h55});
    send(12, {4'd15, 8'hAA});
    check_all("R5");

    send(11, {5'b0, 4'd3, 7'h2A});
    send(13, {3'b0, 1'b1, 4'd2, 8'h77});
    check_all("R3");

    ser_cs_n = 1'b1;
    for (int i = 0; i < 14; i++) begin
      ser_din = i[0];
      tick(4); ser_clk = 1'b1; tick(4); ser_clk = 1'b0;
    end
    tick(10);
    check_all("R6");

    frame_body(12, {4'd4, 8'h3C});
    ser_cs_n = 1'b1;
    tick(3);
    check_all("R8 old after third edge");
    model(12, {4'd4, 8'h3C});
    tick(1);
    check_all("R8 new after fourth edge");
    tick(10);

    pd_req = 1'b1;
    tick(1);
    check_bit("R7 status high", pd_status, 1'b1);
    check_all("R7 codes kept on entry");
    send(12, {4'd9, 8'h9D});
    check_all("R7 write in power-down");
    pd_req = 1'b0;
    tick(1);
    check_bit("R7 status low", pd_status, 1'b0);
    check_all("R7 codes kept on exit");

    for (int n = 0; n < 60; n++) begin
      int unsigned r = $urandom;
      int nb = (r[3:0] == 4'd0) ? 11 : (r[3:0] == 4'd1) ? 13 : 12;
      send(nb, 16'(r >> 8));
      check_all(nb != 12 ? "R3 random" : (r[19:16] >= 4'd12 ? "R5 random" : "R2 R4 random"));
    end

    do_reset();
    check_all("R1 second reset");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule